// File: doc/BRIEF.md
# Binary Scalar-Multiplication Controller

This block sequences the computation of Q = nP for an elliptic-curve engine. A scalar n of up to NMAX bits and its active length k are captured on a start pulse. The controller then walks the scalar from bit k-1 down to bit 0. It doubles the accumulator once per remaining bit and adds the base point P wherever the bit is set. The actual point arithmetic is done by an external point-operation unit. The controller sends that unit one command at a time over a pulse/done handshake and never sends the next command before the unit has signalled done.

The accumulator is seeded from the top active bit of the scalar: Q = P when that bit is one, and Q = O (the point at infinity) otherwise. The controller keeps its own record of whether Q is O, and of whether Q is still exactly the base point that has not yet been written into the unit's accumulator register. Doubling O and adding P to O are resolved internally without a command, so the unit only sees operations with a nontrivial result. When the scan ends, done pulses and two flags tell the consumer where the result lives: O, the base point itself, or the unit's accumulator.

Top module: `scm_ctrl`

## Requirements
- R1: After reset, busy, done and cmd_valid are all 0.
- R2: The accumulator is seeded from bit k-1 of the scalar. If that bit is 1, Q equals P, and with k = 1 done comes back with res_base = 1 and res_inf = 0. If that bit is 0, Q is O, and with k = 1 done comes back with res_inf = 1.
- R3: For each bit i from k-2 down to 0, Q is doubled and then, if bit i is 1, P is added. The final result is (n mod 2^k)·P. The result is read as O when res_inf = 1, as P when res_base = 1, and otherwise as the unit's accumulator.
- R4: No command is issued while Q is O. Doubling O leaves O, and adding P to O makes Q equal to P, both with no command. If the most significant set bit among the k active bits is at position m, the controller issues exactly m double commands and popcount(n mod 2^k) - 1 add commands.
- R5: cmd_op = 0 means double and cmd_op = 1 means add Q + P. cmd_src = 1 tells the unit to take the base point as the Q operand, and cmd_src = 0 tells it to take its accumulator. A double issued while Q equals P uses cmd_src = 1. An add always uses cmd_src = 0.
- R6: cmd_valid is a one-cycle pulse, and a new command is issued only after unit_done. With a unit that answers every command with done L cycles after the pulse, done appears in cycle 2k-1 + C·(L+1) after the start edge, where C is the number of commands.
- R7: If k = 0 or n mod 2^k = 0, the result is O (res_inf = 1) and no command is issued. With k = 0, done comes in cycle 1.
- R8: A start pulse while busy is ignored, and the run in progress completes with its original result.
- R9: Scalar bits at or above position k do not affect the result. A k larger than NMAX is treated as NMAX. Scalar changes after the start edge have no effect.
- R10: busy is 1 from the cycle after the start edge through the done cycle. done is a single-cycle pulse. busy and done are both 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| scalar | input | NMAX | Scalar n |
| bitlen | input | LW | Active length k, LW = clog2(NMAX+1) |
| unit_done | input | 1 | Point unit finished the last command |
| cmd_valid | output | 1 | One-cycle command pulse to the point unit |
| cmd_op | output | 1 | 0 = double, 1 = add Q + P |
| cmd_src | output | 1 | Q operand source: 1 = base point, 0 = accumulator |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result ready (one cycle) |
| res_inf | output | 1 | Result is the point at infinity |
| res_base | output | 1 | Result equals the base point P |

## Verification
Each start edge is followed by a fixed schedule. A decision that needs no command costs one cycle. A decision that does need a command costs one cycle plus the L+1 cycles spent waiting for the modelled unit. So done is due in exactly cycle 2k-1 + C·(L+1), or in cycle 1 for k = 0. The bench drives at the falling edge and counts falling edges from the start edge. It compares the cycle in which done is first seen with that formula, and checks busy in cycle 1 and the idle state in the cycle after done. The modelled unit raises unit_done exactly L cycles after it sees cmd_valid. It also keeps the accumulator as an integer multiple of P, so the product, the command counts and the operand selections are all checked against values computed from the scalar alone.

// File: rtl/scm_pkg.sv
// Shared types for the scalar-multiplication controller.
// Assumes: nothing beyond the standard language.
package scm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } scm_state_e;

    localparam logic OP_DBL = 1'b0;
    localparam logic OP_ADD = 1'b1;
    localparam logic SRC_ACC  = 1'b0;
    localparam logic SRC_BASE = 1'b1;
endpackage

// File: rtl/scm_scalar_reg.sv
// Captures the scalar on load and serves one bit at the scan index.
// Also clamps the requested length to NMAX and exposes the seed bit
// (bit k-1 of the incoming scalar) for the load cycle.
// Assumes: load is a single-cycle strobe; idx < NMAX.
module scm_scalar_reg #(
    parameter int NMAX = 256,
    parameter int LW   = $clog2(NMAX + 1),
    parameter int IW   = $clog2(NMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NMAX-1:0] scalar_in,
    input  logic [LW-1:0]   bitlen_in,
    input  logic [IW-1:0]   idx,
    output logic [LW-1:0]   len_c,
    output logic            seed_bit,
    output logic            cur_bit
);
    logic [NMAX-1:0] scalar_q;
    logic [IW-1:0]   top_idx;

    // Clamp the requested length to the storage width.
    always_comb begin
        len_c   = (bitlen_in > LW'(NMAX)) ? LW'(NMAX) : bitlen_in;
        top_idx = IW'(len_c - LW'(1));
        seed_bit = (len_c != '0) ? scalar_in[top_idx] : 1'b0;
    end

    // Hold the scalar for the duration of a run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scalar_q <= '0;
        else if (load)
            scalar_q <= scalar_in;
    end

    assign cur_bit = scalar_q[idx];
endmodule

// File: rtl/scm_seq.sv
// Sequencer for the double-and-add scan. Tracks whether the
// accumulator is the point at infinity and whether it still equals the
// base point, and issues commands only for nontrivial operations.
// Assumes: the point unit raises unit_done at least one cycle after a
// cmd_valid pulse, exactly once per command.
module scm_seq
    import scm_pkg::*;
#(
    parameter int NMAX = 256,
    parameter int LW   = $clog2(NMAX + 1),
    parameter int IW   = $clog2(NMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len_c,
    input  logic          seed_bit,
    input  logic          cur_bit,
    input  logic          unit_done,
    output logic          load,
    output logic [IW-1:0] idx,
    output logic          cmd_valid,
    output logic          cmd_op,
    output logic          cmd_src,
    output logic          busy,
    output logic          done,
    output logic          res_inf,
    output logic          res_base
);
    scm_state_e state;
    logic       dbl_phase;
    logic       q_inf;
    logic       q_base;

    assign load     = start && (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign res_inf  = q_inf;
    assign res_base = q_base;

    // Main scan state machine: seed, double/add decisions, handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            dbl_phase <= 1'b1;
            q_inf     <= 1'b0;
            q_base    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_DBL;
            cmd_src   <= SRC_ACC;
        end else begin
            cmd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        dbl_phase <= 1'b1;
                        if (len_c == '0) begin
                            q_inf  <= 1'b1;
                            q_base <= 1'b0;
                            state  <= ST_FIN;
                        end else begin
                            q_inf  <= ~seed_bit;
                            q_base <= seed_bit;
                            idx    <= IW'(len_c - LW'(2));
                            state  <= (len_c == LW'(1)) ? ST_FIN : ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    if (dbl_phase) begin
                        if (q_inf) begin
                            dbl_phase <= 1'b0;
                        end else begin
                            cmd_valid <= 1'b1;
                            cmd_op    <= OP_DBL;
                            cmd_src   <= q_base ? SRC_BASE : SRC_ACC;
                            state     <= ST_WAIT;
                        end
                    end else if (cur_bit && !q_inf) begin
                        cmd_valid <= 1'b1;
                        cmd_op    <= OP_ADD;
                        cmd_src   <= SRC_ACC;
                        state     <= ST_WAIT;
                    end else begin
                        if (cur_bit) begin
                            q_inf  <= 1'b0;
                            q_base <= 1'b1;
                        end
                        dbl_phase <= 1'b1;
                        if (idx == '0) state <= ST_FIN;
                        else           idx   <= idx - IW'(1);
                    end
                end
                ST_WAIT: begin
                    if (unit_done) begin
                        q_base <= 1'b0;
                        if (dbl_phase) begin
                            dbl_phase <= 1'b0;
                            state     <= ST_STEP;
                        end else begin
                            dbl_phase <= 1'b1;
                            if (idx == '0) begin
                                state <= ST_FIN;
                            end else begin
                                idx   <= idx - IW'(1);
                                state <= ST_STEP;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: the unit never receives work while the accumulator is O.
    assert_no_cmd_on_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !res_inf);

    // R5: additions always take the accumulator as the Q operand.
    assert_add_uses_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ADD) |-> (cmd_src == SRC_ACC));

    // R6: a command is a single-cycle pulse.
    assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: no second command until the unit answered.
    assert_wait_for_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !unit_done) |=> !cmd_valid);

    // R10: done lasts one cycle and is followed by idle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8: a run in progress stays busy until done, whatever start does.
    assert_stay_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3: the result is never flagged as both O and P.
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_inf && res_base));
endmodule

// File: rtl/scm_ctrl.sv
// Top of the binary scalar-multiplication controller: scalar capture
// plus the double-and-add sequencer driving an external point unit.
// Assumes: the point unit keeps the accumulator and knows the base point.
module scm_ctrl #(
    parameter int NMAX = 256,
    parameter int LW   = $clog2(NMAX + 1),
    parameter int IW   = $clog2(NMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NMAX-1:0] scalar,
    input  logic [LW-1:0]   bitlen,
    input  logic            unit_done,
    output logic            cmd_valid,
    output logic            cmd_op,
    output logic            cmd_src,
    output logic            busy,
    output logic            done,
    output logic            res_inf,
    output logic            res_base
);
    logic          load;
    logic [IW-1:0] idx;
    logic [LW-1:0] len_c;
    logic          seed_bit;
    logic          cur_bit;

    scm_scalar_reg #(.NMAX(NMAX), .LW(LW), .IW(IW)) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .scalar_in (scalar),
        .bitlen_in (bitlen),
        .idx       (idx),
        .len_c     (len_c),
        .seed_bit  (seed_bit),
        .cur_bit   (cur_bit)
    );

    scm_seq #(.NMAX(NMAX), .LW(LW), .IW(IW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_c     (len_c),
        .seed_bit  (seed_bit),
        .cur_bit   (cur_bit),
        .unit_done (unit_done),
        .load      (load),
        .idx       (idx),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_src   (cmd_src),
        .busy      (busy),
        .done      (done),
        .res_inf   (res_inf),
        .res_base  (res_base)
    );
endmodule

// File: tb/sim_scm_ctrl.sv
module sim_scm_ctrl;
    localparam int NMAX = 256;
    localparam int LW   = $clog2(NMAX + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NMAX-1:0] scalar = '0;
    logic [LW-1:0]   bitlen = '0;
    logic            unit_done = 1'b0;
    logic            cmd_valid, cmd_op, cmd_src, busy, done, res_inf, res_base;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 1;
    int pend     = 0;
    int n_dbl, n_add, n_badsrc;
    longint unsigned acc;
    int cycles_total = 0;

    always #2 clk = ~clk;  // 250 MHz

    scm_ctrl #(.NMAX(NMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
        .bitlen(bitlen), .unit_done(unit_done), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_src(cmd_src), .busy(busy), .done(done),
        .res_inf(res_inf), .res_base(res_base)
    );

    // Point-unit model: accumulator kept as an integer multiple of P.
    always @(negedge clk) begin
        unit_done = 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) unit_done = 1'b1;
        end
        if (cmd_valid) begin
            pend = lat;
            if (cmd_op == 1'b0) begin
                n_dbl = n_dbl + 1;
                acc = 2 * (cmd_src ? 64'd1 : acc);
            end else begin
                n_add = n_add + 1;
                if (cmd_src) n_badsrc = n_badsrc + 1;
                acc = acc + 1;
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles_total = cycles_total + 1;
        if (cycles_total > 150000) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cycles_total);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int clampk(input int k);
        return (k > NMAX) ? NMAX : k;
    endfunction

    function automatic longint unsigned exp_val(input logic [NMAX-1:0] sc, input int k);
        longint unsigned v = 0;
        for (int i = 0; i < clampk(k) && i < 64; i++) if (sc[i]) v = v | (64'd1 << i);
        return v;
    endfunction

    function automatic int exp_lead(input logic [NMAX-1:0] sc, input int k);
        int m = -1;
        for (int i = 0; i < clampk(k); i++) if (sc[i]) m = i;
        return m;
    endfunction

    function automatic int exp_pop(input logic [NMAX-1:0] sc, input int k);
        int c = 0;
        for (int i = 0; i < clampk(k); i++) if (sc[i]) c = c + 1;
        return c;
    endfunction

    task automatic run(input logic [NMAX-1:0] sc, input int k, input int l, input bit poke);
        int cyc;
        int kc = clampk(k);
        int lead = exp_lead(sc, k);
        int e_dbl = (lead >= 0) ? lead : 0;
        int e_add = (lead >= 0) ? exp_pop(sc, k) - 1 : 0;
        int e_cyc = (kc == 0) ? 1 : 2 * kc - 1 + (e_dbl + e_add) * (l + 1);
        longint unsigned ev = exp_val(sc, k);
        longint unsigned got;
        @(negedge clk);
        lat = l; n_dbl = 0; n_add = 0; n_badsrc = 0; acc = 0;
        scalar = sc; bitlen = LW'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scalar = ~sc;  // R9: changes after the start edge must not matter
        cyc = 1;
        check(busy === 1'b1, "R10 busy in cycle 1", longint'(busy), 1);
        while (!done && cyc < 4000) begin
            start = (poke && cyc == 3) ? 1'b1 : 1'b0;  // R8 stray start
            @(negedge clk);
            cyc = cyc + 1;
        end
        start = 1'b0;
        got = res_inf ? 64'd0 : (res_base ? 64'd1 : acc);
        check(got == ev, "R3 product multiple", longint'(got), longint'(ev));
        check(res_inf === (ev == 0), "R7 infinity flag", longint'(res_inf), longint'(ev == 0));
        check(n_dbl == e_dbl, "R4 double count", n_dbl, e_dbl);
        check(n_add == e_add, "R4 add count", n_add, e_add);
        check(n_badsrc == 0, "R5 add operand source", n_badsrc, 0);
        check(cyc == e_cyc, "R6 done cycle", cyc, e_cyc);
        @(negedge clk);
        check(!busy && !done, "R10 idle after done", {busy, done}, 0);
    endtask

    initial begin
        logic [NMAX-1:0] sc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !done && !cmd_valid, "R1 reset outputs", {busy, done, cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmd_valid, "R1 idle after reset", {busy, done, cmd_valid}, 0);

        run(256'd5, 0, 1, 1'b0);                     // R7 k = 0
        run(256'd1, 1, 1, 1'b0);                     // R2 seed is P
        check(res_base === 1'b1, "R2 seed P flag", longint'(res_base), 1);
        run(256'd2, 1, 1, 1'b0);                     // R2 seed is O, R9 upper bit
        run(256'd0, 8, 2, 1'b0);                     // R7 zero scalar
        run(256'h80, 8, 2, 1'b0);                    // R5 first double from base
        run(256'h01, 8, 3, 1'b0);                    // R4 P added to O, no command
        run(256'hFF, 8, 1, 1'b0);                    // R3 dense ones
        run(256'h0F0, 12, 2, 1'b0);
        run(256'h5, 300, 1, 1'b0);                   // R9 k above NMAX
        run(256'hA5C3, 16, 2, 1'b1);                 // R8 start while busy
        run({128'h0, {4{32'hFFFF_FFFF}}}, 20, 1, 1'b0); // R9 bits above k ignored

        for (int t = 0; t < 30; t++) begin
            sc = '0;
            for (int w = 0; w < NMAX / 32; w++) sc[w*32 +: 32] = $urandom;
            run(sc, 1 + int'($urandom % 40), 1 + int'($urandom % 3), t % 7 == 0);
        end
        summary();
    end
endmodule